// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a synchronous host and an asynchronous 16-bit EDO DRAM. It turns host word or byte read and write requests into the RAS#, two byte CAS# strobes, WE# and OE# sequences and the multiplexed row/column address the memory expects. Writes are always early writes. Reads are captured from the data pins after the access time and returned on a one-cycle response. Every analog minimum and maximum comes in as a picosecond parameter and is turned into a whole number of clock cycles, rounded up.

A row stays open across page-mode CAS cycles while back-to-back requests hit the same row and the RAS# low time still has room for one more slot. A row miss, an idle host, a refresh request or an exhausted RAS# window closes the row. The row then precharges before another one opens. An external refresh block asks for the bus with `ref_req`. The controller finishes the access in flight, precharges, and raises `ref_gnt` with every strobe high. It keeps the grant until the request drops.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ras_n`, `casl_n`, `cash_n`, `we_n` and `oe_n` are 1, and `dq_oe`, `ref_gnt`, `req_ack` and `rsp_valid` are 0.
- R2: Word address bits [21:10] are the row, driven on `dram_addr` when `ras_n` falls. Bits [9:0] are the column, driven zero-extended to 12 bits when a CAS strobe falls.
- R3: `req_be[0]` selects the low lane (data bits 7..0, strobe `casl_n`) and `req_be[1]` selects the high lane (bits 15..8, strobe `cash_n`). A lane that is not selected keeps its strobe high. No CAS strobe is ever low while `ras_n` is high.
- R4: A write drives `we_n` low at least one cycle before its CAS strobes fall. It holds `oe_n` high and drives `dq_out` with `dq_oe` for the whole cycle. `dq_oe` and a low `oe_n` never coincide.
- R5: A read gives exactly one `rsp_valid` pulse per accepted read, in request order. `rsp_rdata` holds the selected lanes from `dq_in`, and any lane not selected reads as zero.
- R6: While a row is open, a request to the same row is accepted at the end of the CAS precharge without `ras_n` rising. Both byte lanes of one CAS cycle use the same operation, and every CAS cycle is followed by a CAS precharge.
- R7: A request to another row closes the open row. `ras_n` stays high for at least the precharge count (8 cycles at 30 ns, 4 ns clock) before it falls again.
- R8: `ras_n` stays low for at least the RAS minimum (13 cycles at 50 ns) on every access.
- R9: `ras_n` never stays low for more than the page-mode RAS maximum in cycles. A same-row request that would overrun it closes the row and reopens it.
- R10: On `ref_req` the controller finishes the access in flight, precharges and raises `ref_gnt` with all strobes high. No host request is acknowledged while the grant is pending or held. After `ref_req` falls the grant drops and host traffic resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in [21:10], column in [9:0] |
| req_be | input | 2 | Byte lane enables: bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | One-cycle read response |
| rsp_rdata | output | 16 | Read data, lanes not enabled read as zero |
| ref_req | input | 1 | Refresh block asks for the bus |
| ref_gnt | output | 1 | Bus handed to the refresh block |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Low-lane column strobe, active low |
| cash_n | output | 1 | High-lane column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dq_out | output | 16 | Data driven to the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 16 | Data returned by the memory |

## Verification
A vector table drives back-to-back word and single-lane reads and writes, grouped into same-row runs with row changes between them. The number of `ras_n` falls shows whether page hits and row misses were told apart. The per-lane strobe counts and the masked read data show whether the lanes were steered correctly. A run of twelve same-row reads against a shortened RAS maximum must split into exactly two row openings, which tells a working window apart from a page that never closes. A refresh request raised in the middle of traffic checks that the access in flight completes, that no acknowledge leaks out while the grant is pending or held, and that the queued read returns the data written just before.

// File: rtl/edo_pkg.sv
package edo_pkg;

    localparam int LANES = 2;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CASLO,
        ST_CASHI,
        ST_GNT
    } edo_state_e;

    typedef struct packed {
        logic             write;
        logic [LANES-1:0] be;
    } edo_op_t;

    function automatic int ps2cyc(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
    parameter int CW      = 16,
    parameter int RAS_MIN = 13,
    parameter int RAS_MAX = 31250,
    parameter int SLOT    = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_low,
    output logic min_met,
    output logic room
);
    logic [CW-1:0] low_q;

    // low_q is (k-1) in the k-th cycle that the row strobe is low
    always_ff @(posedge clk) begin
        if (rst || !ras_low) begin
            low_q <= '0;
        end else if (low_q != {CW{1'b1}}) begin
            low_q <= low_q + 1'b1;
        end
    end

    assign min_met = (low_q >= CW'(RAS_MIN - 1));
    assign room    = ({1'b0, low_q} + (CW+1)'(SLOT)) < (CW+1)'(RAS_MAX);
endmodule

// File: rtl/edo_lane_path.sv
module edo_lane_path #(
    parameter int LANE_W = 8,
    parameter int NLANE  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      strobe_on,
    input  logic [NLANE-1:0]          be,
    input  logic                      capture,
    input  logic [NLANE*LANE_W-1:0]   dq_in,
    output logic [NLANE-1:0]          cas_n,
    output logic [NLANE*LANE_W-1:0]   rdata
);
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                cas_n[i] <= 1'b1;
                rdata[i*LANE_W +: LANE_W] <= '0;
            end else begin
                cas_n[i] <= !(strobe_on && be[i]);
                if (capture) begin
                    rdata[i*LANE_W +: LANE_W] <= be[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
                end
            end
        end
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 10,
    parameter int LANE_W     = 8,
    parameter int CLK_PS     = 4000,
    parameter int T_RCD_PS   = 11000,
    parameter int T_RP_PS    = 30000,
    parameter int T_RAS_PS   = 50000,
    parameter int T_CAS_PS   = 8000,
    parameter int T_CP_PS    = 8000,
    parameter int T_PC_PS    = 20000,
    parameter int T_AA_PS    = 25000,
    parameter int T_CAC_PS   = 13000,
    parameter int T_RASP_PS  = 125000000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ROW_W+COL_W-1:0]    req_addr,
    input  logic [LANES-1:0]          req_be,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    output logic                      req_ack,
    output logic                      rsp_valid,
    output logic [LANES*LANE_W-1:0]   rsp_rdata,
    input  logic                      ref_req,
    output logic                      ref_gnt,
    output logic                      ras_n,
    output logic                      casl_n,
    output logic                      cash_n,
    output logic                      we_n,
    output logic                      oe_n,
    output logic [ROW_W-1:0]          dram_addr,
    output logic [LANES*LANE_W-1:0]   dq_out,
    output logic                      dq_oe,
    input  logic [LANES*LANE_W-1:0]   dq_in
);
    localparam int ADDR_W   = ROW_W + COL_W;
    localparam int N_RCD    = imax(1, ps2cyc(T_RCD_PS, CLK_PS));
    localparam int N_RP     = imax(1, ps2cyc(T_RP_PS, CLK_PS));
    localparam int N_RAS    = imax(1, ps2cyc(T_RAS_PS, CLK_PS));
    localparam int N_CAS    = imax(1, ps2cyc(T_CAS_PS, CLK_PS));
    localparam int N_CP     = imax(1, ps2cyc(T_CP_PS, CLK_PS));
    localparam int N_PC     = ps2cyc(T_PC_PS, CLK_PS);
    localparam int N_AA     = ps2cyc(T_AA_PS, CLK_PS);
    localparam int N_CAC    = ps2cyc(T_CAC_PS, CLK_PS);
    localparam int N_RASMAX = ps2cyc(T_RASP_PS, CLK_PS);
    // read strobe width: sample one cycle past both access times
    localparam int L_RD     = imax(N_CAS, imax(N_CAC + 1, N_AA));
    // precharge long enough that a write slot meets the page cycle
    localparam int N_CPW    = imax(N_CP, N_PC - 1 - N_CAS);
    localparam int SLOT     = 1 + L_RD + N_CPW;
    localparam int TW       = $clog2(imax(N_RP, imax(L_RD, imax(N_RCD, N_CPW))) + 1) + 1;
    localparam int CW       = $clog2(N_RASMAX + 1) + 1;

    edo_state_e state_q, state_d;
    edo_op_t    op_q;
    logic [ROW_W-1:0] row_q, req_row;
    logic [COL_W-1:0] col_q, req_col;
    logic             tmr_done, tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             min_met, room;
    logic             hit, accept, wr_next;
    logic             strobe_on, capture;
    logic             ras_n_q, we_n_q, oe_n_q, dq_oe_q, gnt_q, rsp_q;
    logic [ROW_W-1:0] addr_q;
    logic [LANES*LANE_W-1:0] wdata_q;
    logic [LANES-1:0] cas_n_vec;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    always_comb begin
        hit    = req_valid && !ref_req && room && (req_row == row_q);
        accept = req_valid &&
                 ((state_q == ST_IDLE && !ref_req) ||
                  (state_q == ST_CASHI && tmr_done && hit));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRE:   if (tmr_done) state_d = ST_IDLE;
            ST_IDLE:  if (ref_req) state_d = ST_GNT;
                      else if (req_valid) state_d = ST_ROW;
            ST_ROW:   state_d = ST_RCD;
            ST_RCD:   if (tmr_done) state_d = ST_COL;
            ST_COL:   state_d = ST_CASLO;
            ST_CASLO: if (tmr_done) state_d = ST_CASHI;
            ST_CASHI: if (tmr_done) begin
                          if (accept) state_d = ST_COL;
                          else if (min_met) state_d = ST_PRE;
                      end
            ST_GNT:   if (!ref_req) state_d = ST_IDLE;
            default:  state_d = ST_PRE;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_PRE:   tmr_val = TW'(N_RP - 1);
            ST_RCD:   tmr_val = TW'(N_RCD - 1);
            ST_CASLO: tmr_val = op_q.write ? TW'(N_CAS - 1) : TW'(L_RD - 1);
            ST_CASHI: tmr_val = TW'(N_CPW - 1);
            default:  tmr_val = '0;
        endcase
    end

    edo_cycle_timer #(
        .W       (TW),
        .RST_VAL (N_RP - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    edo_ras_window #(
        .CW      (CW),
        .RAS_MIN (N_RAS),
        .RAS_MAX (N_RASMAX),
        .SLOT    (SLOT)
    ) u_window (
        .clk     (clk),
        .rst     (rst),
        .ras_low (!ras_n_q),
        .min_met (min_met),
        .room    (room)
    );

    assign wr_next   = accept ? req_write : op_q.write;
    assign strobe_on = (state_d == ST_CASLO);
    assign capture   = (state_q == ST_CASLO) && tmr_done && !op_q.write;

    edo_lane_path #(
        .LANE_W (LANE_W),
        .NLANE  (LANES)
    ) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .strobe_on (strobe_on),
        .be        (op_q.be),
        .capture   (capture),
        .dq_in     (dq_in),
        .cas_n     (cas_n_vec),
        .rdata     (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRE;
            op_q    <= '0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            addr_q  <= '0;
            ras_n_q <= 1'b1;
            we_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            gnt_q   <= 1'b0;
            rsp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                row_q    <= req_row;
                col_q    <= req_col;
                op_q     <= '{write: req_write, be: req_be};
                wdata_q  <= req_wdata;
            end
            if (state_d == ST_ROW) begin
                addr_q <= req_row;
            end else if (state_d == ST_COL) begin
                addr_q <= ROW_W'(accept ? req_col : col_q);
            end
            ras_n_q <= !(state_d inside {ST_RCD, ST_COL, ST_CASLO, ST_CASHI});
            we_n_q  <= !((state_d inside {ST_COL, ST_CASLO, ST_CASHI}) && wr_next);
            oe_n_q  <= !((state_d inside {ST_COL, ST_CASLO}) && !wr_next);
            dq_oe_q <= (state_d inside {ST_COL, ST_CASLO, ST_CASHI}) && wr_next;
            gnt_q   <= (state_d == ST_GNT);
            rsp_q   <= capture;
        end
    end

    assign req_ack   = accept;
    assign rsp_valid = rsp_q;
    assign ref_gnt   = gnt_q;
    assign ras_n     = ras_n_q;
    assign casl_n    = cas_n_vec[0];
    assign cash_n    = cas_n_vec[1];
    assign we_n      = we_n_q;
    assign oe_n      = oe_n_q;
    assign dram_addr = addr_q;
    assign dq_out    = wdata_q;
    assign dq_oe     = dq_oe_q;
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
    parameter int RAS_MIN = 13,
    parameter int RAS_MAX = 31250,
    parameter int RP_MIN  = 8
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic casl_n,
    input logic cash_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic ref_gnt
);
    logic [31:0] low_cnt, high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            low_cnt  <= ras_n ? '0 : low_cnt + 1;
            high_cnt <= ras_n ? high_cnt + 1 : '0;
        end
    end

    a_r8_ras_min: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_cnt >= 32'(RAS_MIN)));

    a_r9_ras_max: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (low_cnt < 32'(RAS_MAX)));

    a_r7_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (high_cnt >= 32'(RP_MIN)));

    a_r4_early_write: assert property (@(posedge clk) disable iff (rst)
        (($fell(casl_n) || $fell(cash_n)) && !we_n) |-> ($past(we_n) == 1'b0));

    a_r4_no_contention: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n);

    a_r3_cas_under_ras: assert property (@(posedge clk) disable iff (rst)
        (!casl_n || !cash_n) |-> !ras_n);

    a_r6_mode_stable: assert property (@(posedge clk) disable iff (rst)
        ((!casl_n || !cash_n) && $past(!casl_n || !cash_n)) |-> $stable(we_n));

    a_r10_gnt_quiet: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (ras_n && casl_n && cash_n));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
    .RAS_MIN (N_RAS),
    .RAS_MAX (N_RASMAX),
    .RP_MIN  (N_RP)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ras_n   (ras_n),
    .casl_n  (casl_n),
    .cash_n  (cash_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dq_oe   (dq_oe),
    .ref_gnt (ref_gnt)
);

// File: tb/tb_edo_dram_ctrl.sv
module tb_edo_dram_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        ref_req = 1'b0;
    logic        ref_gnt, ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
    logic [11:0] dram_addr;
    logic [15:0] dq_out, dq_in;

    always #2 clk = ~clk;   // 250 MHz

    edo_dram_ctrl #(.T_RASP_PS(400000)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .ras_n(ras_n), .casl_n(casl_n),
        .cash_n(cash_n), .we_n(we_n), .oe_n(oe_n), .dram_addr(dram_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem [0:255];
    logic [11:0] lat_row = '0, lat_col = '0;
    int ras_falls = 0, casl_falls = 0, cash_falls = 0, wr_viol = 0;
    logic [7:0] cur;

    initial for (int i = 0; i < 256; i++) mem[i] = '0;

    always @(negedge ras_n) begin
        lat_row = dram_addr;
        ras_falls++;
    end
    always @(negedge casl_n) casl_falls++;
    always @(negedge cash_n) cash_falls++;

    always @(negedge casl_n or negedge cash_n) begin
        lat_col = dram_addr;
        if (!we_n) begin
            if (!dq_oe || !oe_n) wr_viol++;
            if (!casl_n) mem[{lat_row[3:0], dram_addr[3:0]}][7:0]  = dq_out[7:0];
            if (!cash_n) mem[{lat_row[3:0], dram_addr[3:0]}][15:8] = dq_out[15:8];
        end
    end

    assign cur = {lat_row[3:0], lat_col[3:0]};
    assign dq_in[7:0]  = (!casl_n && we_n && !oe_n) ? mem[cur][7:0]  : 8'h00;
    assign dq_in[15:8] = (!cash_n && we_n && !oe_n) ? mem[cur][15:8] : 8'h00;

    // ---------------- read response monitor ----------------
    logic [15:0] exp_rd [0:63];
    int exp_push = 0, exp_pop = 0, rsp_wide = 0;
    logic rsp_prev = 1'b0;
    int hi_run = 0, lo_run = 0, min_hi = 1000, min_lo = 1000;
    logic ras_prev = 1'b1;
    bit seen_low = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                check("R5 read data", {16'h0, rsp_rdata}, {16'h0, exp_rd[exp_pop]});
                exp_pop++;
                if (rsp_prev) rsp_wide++;
            end
            rsp_prev = rsp_valid;
            if (ras_n) begin
                if (!ras_prev && lo_run < min_lo) min_lo = lo_run;
                if (!ras_prev) lo_run = 0;
                hi_run++;
            end else begin
                if (ras_prev && seen_low && hi_run < min_hi) min_hi = hi_run;
                if (ras_prev) hi_run = 0;
                seen_low = 1;
                lo_run++;
            end
            ras_prev = ras_n;
        end
    end

    // ---------------- host tasks ----------------
    task automatic issue(input logic wr, input logic [21:0] a, input logic [1:0] be,
                         input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        forever begin
            #1;
            if (req_ack) break;
            @(negedge clk);
        end
        if (!wr) begin
            exp_rd[exp_push] = d;
            exp_push++;
        end
    endtask

    task automatic drain();
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !(exp_pop == exp_push && ras_n); i++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // {write, addr[21:0], be[1:0], data[15:0]}: data is write data or expected read
    localparam logic [40:0] VEC [12] = '{
        {1'b1, 22'h000402, 2'b11, 16'hA5A5},
        {1'b1, 22'h000403, 2'b01, 16'h00C3},
        {1'b1, 22'h000403, 2'b10, 16'h7E00},
        {1'b0, 22'h000402, 2'b11, 16'hA5A5},
        {1'b0, 22'h000403, 2'b11, 16'h7EC3},
        {1'b0, 22'h000803, 2'b11, 16'h0000},
        {1'b1, 22'h000803, 2'b11, 16'h1234},
        {1'b0, 22'h000403, 2'b01, 16'h00C3},
        {1'b0, 22'h000403, 2'b10, 16'h7E00},
        {1'b0, 22'h000803, 2'b11, 16'h1234},
        {1'b1, 22'h00140F, 2'b11, 16'hFFFF},
        {1'b0, 22'h00140F, 2'b10, 16'hFF00}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R1..R10 incomplete)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int falls0, acks_bad, n;
        // R1 reset values
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {23'h0, ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, ref_gnt, req_ack, rsp_valid},
              32'b1_1111_0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {23'h0, ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, ref_gnt, req_ack, rsp_valid},
              32'b1_1111_0000);

        // vector table, back to back
        foreach (VEC[i]) issue(VEC[i][40], VEC[i][39:18], VEC[i][17:16], VEC[i][15:0]);
        drain();

        check("R6 R7 row openings for table", ras_falls, 5);
        check("R3 low lane strobes", casl_falls, 9);
        check("R3 high lane strobes", cash_falls, 10);
        check("R2 row latched", {20'h0, lat_row}, 32'h5);
        check("R2 column latched", {20'h0, lat_col}, 32'hF);
        check("R4 write strobe without drive or with output enabled", wr_viol, 0);
        check("R5 responses returned", exp_pop, exp_push);

        // R9 RAS window: twelve same-row reads split into two openings
        falls0 = ras_falls;
        for (int i = 0; i < 12; i++) issue(1'b0, 22'h001000 | 22'(i), 2'b11, 16'h0000);
        drain();
        check("R9 openings for long same-row burst", ras_falls - falls0, 2);
        check("R2 row of burst", {20'h0, lat_row}, 32'h4);

        // R10 refresh handover
        issue(1'b1, 22'h000C01, 2'b11, 16'hBEEF);
        @(negedge clk);
        ref_req = 1'b1;
        req_write = 1'b0; req_addr = 22'h000C01; req_be = 2'b11; req_valid = 1'b1;
        acks_bad = 0;
        n = 0;
        while (!ref_gnt && n < 200) begin
            #1;
            if (req_ack) acks_bad++;
            @(negedge clk);
            n++;
        end
        check("R10 grant raised", {31'h0, ref_gnt}, 32'h1);
        for (int i = 0; i < 10; i++) begin
            #1;
            if (req_ack || !ras_n || !casl_n || !cash_n) acks_bad++;
            @(negedge clk);
        end
        check("R10 no host ack and bus quiet under refresh", acks_bad, 0);
        ref_req = 1'b0;
        n = 0;
        forever begin
            #1;
            if (req_ack || n > 50) break;
            @(negedge clk);
            n++;
        end
        check("R10 host resumes after release", {31'h0, req_ack}, 32'h1);
        check("R10 grant dropped", {31'h0, ref_gnt}, 32'h0);
        exp_rd[exp_push] = 16'hBEEF;
        exp_push++;
        drain();
        check("R5 refresh test response", exp_pop, exp_push);
        check("R5 single-cycle response pulses", rsp_wide, 0);
        check("R7 shortest precharge >= 8", {31'h0, min_hi >= 8}, 32'h1);
        check("R8 shortest RAS low >= 13", {31'h0, min_lo >= 13}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule